// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block sits beside a tuner's register bank and owns three things: the choice of control-bus flavour, the forcing of register defaults while the chip reset is asserted, and the power state machine driven by two control bits. The chip reset `rst_n` is active low and is sampled on `clk`. On the first clock edge that sees it high after a low period, the bus-select pin is captured once. That choice then holds until the next reset.

Software powers the device up by writing the enable bit set with the disable bit clear. It powers the device down by writing both bits set. A powerdown runs for a fixed, parameterized number of cycles. At the end the hardware returns to the off state and clears both bits by itself. Three 2-bit fields of the configuration register are expected to read `10b` before a powerdown is requested. A request made without that setup raises a sticky error flag, and the powerdown still goes ahead. Writes that try to clear the enable bit are discarded.

Top module: `rpm_ctrl`

## Requirements
- R1: Every clock edge that samples `rst_n` low leaves `bus_en`=0, `two_wire`=0, `pwr_state`=00 (off), `en_bit`=0, `dis_bit`=0, `pd_done`=0, `cfg_err`=0 and `cfg_fields`=0 after that edge.
- R2: On the first edge that samples `rst_n` high after a low period, `two_wire` takes `bus_sel` (1 = two-wire, 0 = three-wire) and `bus_en` becomes 1. `two_wire` then ignores `bus_sel` until the next reset.
- R3: Strobes on `wr_pwr` or `wr_cfg` at an edge where `bus_en` is still 0 (including the edge that releases reset) change nothing.
- R4: A power write with data bit 0 (enable) = 1 and bit 1 (disable) = 0, made in the off (00) or up (01) state, gives `pwr_state`=01, `en_bit`=1 and `dis_bit`=0 after that edge.
- R5: A power write with both data bits set, made in state 00 or 01, gives `pwr_state`=10 (powering down) with `en_bit`=`dis_bit`=1. This state is held for exactly `PD_CYCLES` consecutive cycles.
- R6: In the cycle the powering-down state ends, `pwr_state` is 00, both `en_bit` and `dis_bit` are 0, and `pd_done` is 1 for that single cycle.
- R7: A power write with data bit 0 (enable) = 0 is ignored, and state and bits stay as they were.
- R8: A power write of any value while `pwr_state`=10 is ignored.
- R9: A configuration write stores `wr_cfg_data[5:0]` into `cfg_fields`, with the three fields at bits 5:4, 3:2 and 1:0.
- R10: A powerdown request made while any field of `cfg_fields` differs from `10b` sets `cfg_err`. The check uses the contents before that edge, so a configuration write at the same edge does not count. The flag stays set until reset, and the request still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, sampled on `clk` |
| bus_sel | input | 1 | Bus flavour select pin, captured at reset release |
| wr_pwr | input | 1 | Write strobe for the power control register |
| wr_pwr_data | input | 2 | Bit 0 enable, bit 1 disable |
| wr_cfg | input | 1 | Write strobe for the configuration register |
| wr_cfg_data | input | 6 | Three 2-bit fields |
| two_wire | output | 1 | Captured bus mode, 1 = two-wire |
| bus_en | output | 1 | Control interface enabled |
| pwr_state | output | 2 | 00 off, 01 up, 10 powering down |
| en_bit | output | 1 | Current enable bit |
| dis_bit | output | 1 | Current disable bit |
| pd_done | output | 1 | One-cycle pulse when powerdown completes and both bits clear |
| cfg_err | output | 1 | Sticky flag for a powerdown requested without field setup |
| cfg_fields | output | 6 | Configuration register contents |

## Verification
A configuration write and a powerdown request can land on the same edge. In that case the field check must use the old register contents while the new contents are stored. The bench provokes this in both directions: it moves the fields from bad to good, and from good to bad, at the edge of the request. It then judges `cfg_err` against the old value. A second collision puts a power-up write inside the powering-down window. The bench judges that write by the unchanged state and by the exact length of the window.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    PWR_OFF   = 2'b00,
    PWR_UP    = 2'b01,
    PWR_PDSEQ = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/rpm_mode_latch.sv
module rpm_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  output logic two_wire,
  output logic bus_en
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      two_wire <= 1'b0;
      bus_en   <= 1'b0;
    end else if (armed) begin
      armed    <= 1'b0;
      two_wire <= bus_sel;
      bus_en   <= 1'b1;
    end
  end
endmodule

// File: rtl/rpm_cfg_reg.sv
module rpm_cfg_reg #(
  parameter int NUM_FIELDS = 3,
  parameter int FIELD_W    = 2,
  parameter logic [FIELD_W-1:0] FIELD_OK = 2'b10,
  localparam int CFG_W = NUM_FIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] fields,
  output logic             fields_ok
);
  logic [NUM_FIELDS-1:0] field_match;

  always_ff @(posedge clk) begin
    if (!rst_n)     fields <= '0;
    else if (wr_en) fields <= wr_data;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign field_match[i] = (fields[i*FIELD_W +: FIELD_W] == FIELD_OK);
  end

  assign fields_ok = &field_match;
endmodule

// File: rtl/rpm_power_fsm.sv
module rpm_power_fsm
  import rpm_pkg::*;
#(
  parameter int PD_CYCLES = 8,
  localparam int CNT_W = (PD_CYCLES > 1) ? $clog2(PD_CYCLES) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       fields_ok,
  output pwr_state_e state,
  output logic       en_bit,
  output logic       dis_bit,
  output logic       pd_done,
  output logic       cfg_err
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic req_up, req_dn;

  assign req_up = wr_en && wr_data[0] && !wr_data[1];
  assign req_dn = wr_en && wr_data[0] &&  wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PWR_OFF;
      en_bit  <= 1'b0;
      dis_bit <= 1'b0;
      pd_done <= 1'b0;
      cfg_err <= 1'b0;
      cnt     <= '0;
    end else begin
      pd_done <= 1'b0;
      case (state)
        PWR_PDSEQ: begin
          if (cnt == LAST) begin
            state   <= PWR_OFF;
            en_bit  <= 1'b0;
            dis_bit <= 1'b0;
            pd_done <= 1'b1;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (req_dn) begin
            state   <= PWR_PDSEQ;
            en_bit  <= 1'b1;
            dis_bit <= 1'b1;
            cnt     <= '0;
            if (!fields_ok) cfg_err <= 1'b1;
          end else if (req_up) begin
            state   <= PWR_UP;
            en_bit  <= 1'b1;
            dis_bit <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
#(
  parameter int PD_CYCLES  = 8,
  parameter int NUM_FIELDS = 3,
  parameter int FIELD_W    = 2,
  localparam int CFG_W = NUM_FIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             wr_pwr,
  input  logic [1:0]       wr_pwr_data,
  input  logic             wr_cfg,
  input  logic [CFG_W-1:0] wr_cfg_data,
  output logic             two_wire,
  output logic             bus_en,
  output logic [1:0]       pwr_state,
  output logic             en_bit,
  output logic             dis_bit,
  output logic             pd_done,
  output logic             cfg_err,
  output logic [CFG_W-1:0] cfg_fields
);
  pwr_state_e st;
  logic       fields_ok;

  rpm_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .two_wire (two_wire),
    .bus_en   (bus_en)
  );

  rpm_cfg_reg #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W),
    .FIELD_OK   (FIELD_W'(2))
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_cfg && bus_en),
    .wr_data   (wr_cfg_data),
    .fields    (cfg_fields),
    .fields_ok (fields_ok)
  );

  rpm_power_fsm #(
    .PD_CYCLES (PD_CYCLES)
  ) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_pwr && bus_en),
    .wr_data   (wr_pwr_data),
    .fields_ok (fields_ok),
    .state     (st),
    .en_bit    (en_bit),
    .dis_bit   (dis_bit),
    .pd_done   (pd_done),
    .cfg_err   (cfg_err)
  );

  assign pwr_state = st;
endmodule

// File: rtl/rpm_ctrl_chk.sv
module rpm_ctrl_chk #(
  parameter int PD_CYCLES = 8,
  localparam int RUN_W = $clog2(PD_CYCLES + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       two_wire,
  input logic       wr_pwr,
  input logic [1:0] wr_pwr_data,
  input logic [1:0] pwr_state,
  input logic       en_bit,
  input logic       dis_bit,
  input logic       pd_done,
  input logic       cfg_err
);
  logic [RUN_W-1:0] pd_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pd_run <= '0;
    else if (pwr_state == 2'b10) pd_run <= pd_run + 1'b1;
    else                         pd_run <= '0;
  end

  assert_defaults_R1: assert property (@(posedge clk)
    !rst_n |=> (!bus_en && pwr_state == 2'b00 && !en_bit && !dis_bit && !cfg_err && !pd_done));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && $past(bus_en)) |-> $stable(two_wire));

  assert_state_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);

  assert_pd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10) |-> (pd_run < RUN_W'(PD_CYCLES) && en_bit && dis_bit));

  assert_pd_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && $past(pwr_state) == 2'b10) |-> (pd_done && !en_bit && !dis_bit));

  assert_en_zero_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && wr_pwr && !wr_pwr_data[0] && pwr_state != 2'b10) |=> $stable(pwr_state));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind rpm_ctrl rpm_ctrl_chk #(.PD_CYCLES(PD_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .two_wire    (two_wire),
  .wr_pwr      (wr_pwr),
  .wr_pwr_data (wr_pwr_data),
  .pwr_state   (pwr_state),
  .en_bit      (en_bit),
  .dis_bit     (dis_bit),
  .pd_done     (pd_done),
  .cfg_err     (cfg_err)
);

// File: tb/rpm_ctrl_bench.sv
module rpm_ctrl_bench;
  localparam int PD = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       wr_pwr = 1'b0;
  logic [1:0] wr_pwr_data = 2'b00;
  logic       wr_cfg = 1'b0;
  logic [5:0] wr_cfg_data = 6'd0;
  logic       two_wire, bus_en, en_bit, dis_bit, pd_done, cfg_err;
  logic [1:0] pwr_state;
  logic [5:0] cfg_fields;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rpm_ctrl #(.PD_CYCLES(PD)) u_rpm_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .wr_pwr(wr_pwr), .wr_pwr_data(wr_pwr_data),
    .wr_cfg(wr_cfg), .wr_cfg_data(wr_cfg_data),
    .two_wire(two_wire), .bus_en(bus_en), .pwr_state(pwr_state),
    .en_bit(en_bit), .dis_bit(dis_bit), .pd_done(pd_done),
    .cfg_err(cfg_err), .cfg_fields(cfg_fields)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(logic bs);
    rst_n = 1'b0;
    tick();
    tick();
    check("R1 bus_en", bus_en, 0);
    check("R1 state", pwr_state, 0);
    check("R1 bits", {en_bit, dis_bit, pd_done, cfg_err, two_wire}, 0);
    check("R1 fields", cfg_fields, 0);
    bus_sel = bs;
    rst_n = 1'b1;
    tick();
    check("R2 mode", two_wire, bs);
    check("R2 bus_en", bus_en, 1);
    bus_sel = ~bs;
    tick();
    check("R2 hold", two_wire, bs);
  endtask

  task automatic pwr_wr(logic [1:0] d);
    wr_pwr = 1'b1;
    wr_pwr_data = d;
    tick();
    wr_pwr = 1'b0;
  endtask

  task automatic cfg_wr(logic [5:0] d);
    wr_cfg = 1'b1;
    wr_cfg_data = d;
    tick();
    wr_cfg = 1'b0;
  endtask

  function automatic bit bad_cfg(logic [5:0] v);
    return (v[5:4] != 2'b10) || (v[3:2] != 2'b10) || (v[1:0] != 2'b10);
  endfunction

  task automatic run_pd(int already);
    int n = already;
    while (pwr_state == 2'b10 && n < 40) begin
      tick();
      if (pwr_state == 2'b10) n++;
    end
    check("R5 window", n, PD);
    check("R6 state", pwr_state, 0);
    check("R6 bits", {en_bit, dis_bit}, 0);
    check("R6 done", pd_done, 1);
    tick();
    check("R6 pulse", pd_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick();
    // R3: strobes during reset and on the releasing edge are dropped
    rst_n = 1'b0;
    wr_cfg = 1'b1; wr_cfg_data = 6'b101010;
    wr_pwr = 1'b1; wr_pwr_data = 2'b01;
    tick();
    bus_sel = 1'b1;
    rst_n = 1'b1;
    tick();
    wr_cfg = 1'b0; wr_pwr = 1'b0;
    check("R3 fields", cfg_fields, 0);
    check("R3 state", pwr_state, 0);
    check("R2 mode", two_wire, 1);

    // Sweep every configuration value through a full power cycle
    for (int v = 0; v < 64; v++) begin
      do_reset(v[0]);
      cfg_wr(6'(v));
      check("R9 fields", cfg_fields, v);
      pwr_wr(2'b00);
      check("R7 from off", pwr_state, 0);
      pwr_wr(2'b01);
      check("R4 state", pwr_state, 1);
      check("R4 bits", {en_bit, dis_bit}, 2'b10);
      pwr_wr(2'b10);
      check("R7 state", pwr_state, 1);
      check("R7 bits", {en_bit, dis_bit}, 2'b10);
      pwr_wr(2'b11);
      check("R5 state", pwr_state, 2);
      check("R5 bits", {en_bit, dis_bit}, 2'b11);
      check("R10 flag", cfg_err, int'(bad_cfg(6'(v))));
      pwr_wr(2'b01);
      check("R8 ignored", pwr_state, 2);
      run_pd(2);
      check("R10 sticky", cfg_err, int'(bad_cfg(6'(v))));
    end

    // R10: same-edge write, bad to good; old contents judged
    do_reset(1'b0);
    wr_cfg = 1'b1; wr_cfg_data = 6'b101010;
    wr_pwr = 1'b1; wr_pwr_data = 2'b11;
    tick();
    wr_cfg = 1'b0; wr_pwr = 1'b0;
    check("R10 same edge bad->good", cfg_err, 1);
    check("R9 same edge store", cfg_fields, 6'b101010);
    run_pd(1);
    pwr_wr(2'b11);
    check("R10 sticky after good request", cfg_err, 1);
    run_pd(1);

    // R10: same-edge write, good to bad
    do_reset(1'b1);
    cfg_wr(6'b101010);
    wr_cfg = 1'b1; wr_cfg_data = 6'b000000;
    wr_pwr = 1'b1; wr_pwr_data = 2'b11;
    tick();
    wr_cfg = 1'b0; wr_pwr = 1'b0;
    check("R10 same edge good->bad", cfg_err, 0);
    check("R5 from off", pwr_state, 2);
    run_pd(1);
    check("R10 no flag", cfg_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule